// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the execution stage of a small 8-bit processor datapath. Each cycle it may accept one operation, given as a 4-bit operation code, an 8-bit operand, the present accumulator value and the present five status flags. The operand may be a register byte, a memory byte or an immediate byte. The block does not know or care which. The instruction decoder, register file and memory interface sit outside. They supply these values and apply what comes back.

One clock after an accepted operation, the block presents a result byte, the updated flags and an accumulator write-enable. Only the accumulator is ever a destination here. Increment and decrement return the stepped operand on the result port, but leave the write-enable low, so the surrounding datapath writes that byte back to wherever the operand came from. Compare, set-carry and complement-carry change only the flags, and return the accumulator unchanged.

Each class of operation has its own flag rule. Additions and subtractions set all five flags. Compare sets them as a subtraction would, but keeps the result. Logic operations always clear carry. Complementing the accumulator leaves every flag alone. Two operations touch carry alone.

Top module: `acc_alu`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge; otherwise `out_valid` is low after the edge. While `rst_n` is low, `out_valid`, `result`, `flags_out` and `acc_we` are all zero.
- R2: Code 0 (add) and code 1 (add with carry) give result = A + operand, plus CY for code 1, modulo 256. CY becomes the carry out of bit 7, AC becomes the carry out of bit 3, and `acc_we` is 1.
- R3: Code 2 (subtract) and code 3 (subtract with borrow) give result = A − operand, minus CY for code 3, modulo 256. CY becomes 1 exactly when a borrow out of bit 7 occurs. AC becomes the borrow into bit 4. `acc_we` is 1.
- R4: The flags are packed as `flags_out[4:0]` = {S, Z, AC, P, CY}, and `flags_in` uses the same layout. Every operation that sets S, Z and P does so from the byte it computed: S copies bit 7, Z = 1 for zero, and P = 1 for an even count of one bits. Adding 0x44 and 0x73 gives 0xB7 with flags 5'b10010.
- R5: Code 4 (AND), code 5 (OR) and code 6 (XOR) write A op operand to the result with `acc_we` = 1. They clear CY, set AC for AND and clear AC for OR and XOR.
- R6: Code 7 (compare) sets the flags as a subtract would. This gives CY = 1 when A < operand and Z = 1 when A equals the operand. The result is A, unchanged, and `acc_we` is 0.
- R7: Code 8 (increment) and code 9 (decrement) give result = operand ± 1 modulo 256 with `acc_we` = 0. They update S, Z, P and AC, where AC is the carry out of bit 3 or the borrow into bit 4, and keep CY unchanged.
- R8: Code 10 (complement) gives result = bitwise NOT of A with `acc_we` = 1 and all flags unchanged.
- R9: Code 11 sets CY to 1 and code 12 inverts CY. Both keep S, Z, AC and P unchanged, return A as the result, and hold `acc_we` at 0.
- R10: Codes 13 to 15 have no effect: the result is A, the flags are unchanged and `acc_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code |
| operand | input | 8 | Second operand byte (register, memory or immediate) |
| acc_in | input | 8 | Current accumulator value |
| flags_in | input | 5 | Current flags {S, Z, AC, P, CY} |
| out_valid | output | 1 | Result registers hold a new outcome |
| result | output | 8 | Computed byte |
| flags_out | output | 5 | Updated flags {S, Z, AC, P, CY} |
| acc_we | output | 1 | Write `result` into the accumulator |

## Verification
On every cycle, the assertions check the following from the ports:
- the one-cycle valid relation;
- that compare never writes and returns the accumulator, with its carry and zero flags obeying the ordering of A and the operand;
- that logic operations clear carry;
- that complement keeps every flag;
- that the carry-only operations keep the other four flags;
- that increment and decrement keep carry;
- that parity follows the produced byte.

Only the bench's scenarios show the exact arithmetic values. These include carry and borrow chains across bit 3 and bit 7, chaining of the incoming carry into add-with-carry and subtract-with-borrow, wraparound of increment at 0xFF and of decrement at 0x00, the reset values, and that the unused codes leave everything untouched.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_CMA = 4'd10,
    OP_STC = 4'd11,
    OP_CMC = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;

  localparam int FLAG_W  = $bits(alu_flags_t);
  localparam int FL_CY   = 0;
  localparam int FL_P    = 1;
  localparam int FL_AC   = 2;
  localparam int FL_Z    = 3;
  localparam int FL_S    = 4;
  localparam int NIB_W   = 4;

endpackage

// File: rtl/acc_alu_arith.sv
`timescale 1ns/1ps
module acc_alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         half
);
  import acc_alu_pkg::*;

  localparam int HW = NIB_W;

  logic [W-1:0]  b_eff;
  logic          c_eff;
  logic [W:0]    full_sum;
  logic [HW:0]   nib_sum;

  // Subtraction is done as a + ~b + ~borrow_in; carry and half carry are
  // then inverted to read as borrow.
  assign b_eff    = sub ? ~b : b;
  assign c_eff    = sub ? ~cin : cin;
  assign full_sum = {1'b0, a} + {1'b0, b_eff} + (W+1)'(c_eff);
  assign nib_sum  = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + (HW+1)'(c_eff);

  assign res  = full_sum[W-1:0];
  assign cout = full_sum[W] ^ sub;
  assign half = nib_sum[HW] ^ sub;

endmodule

// File: rtl/acc_alu_logic.sv
`timescale 1ns/1ps
module acc_alu_logic #(
  parameter int W = 8
) (
  input  acc_alu_pkg::alu_op_e op,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic [W-1:0]         res,
  output logic                 half
);
  import acc_alu_pkg::*;

  always_comb begin
    res  = a ^ b;
    half = 1'b0;
    case (op)
      OP_AND: begin
        res  = a & b;
        half = 1'b1;
      end
      OP_OR:   res = a | b;
      default: res = a ^ b;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu #(
  parameter int W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [3:0]                   op,
  input  logic [W-1:0]                 operand,
  input  logic [W-1:0]                 acc_in,
  input  logic [acc_alu_pkg::FLAG_W-1:0] flags_in,
  output logic                         out_valid,
  output logic [W-1:0]                 result,
  output logic [acc_alu_pkg::FLAG_W-1:0] flags_out,
  output logic                         acc_we
);
  import acc_alu_pkg::*;

  localparam int HW = NIB_W;

  function automatic alu_flags_t put_szp(input alu_flags_t f, input logic [W-1:0] v);
    alu_flags_t o;
    o   = f;
    o.s = v[W-1];
    o.z = (v == '0);
    o.p = ~^v;
    return o;
  endfunction

  alu_op_e    op_e;
  alu_flags_t fin;
  assign op_e = alu_op_e'(op);
  assign fin  = alu_flags_t'(flags_in);

  // Named internal events
  logic       is_sub;
  logic       uses_cy;
  logic       is_dec;
  assign is_sub  = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP);
  assign uses_cy = (op_e == OP_ADC) || (op_e == OP_SBB);
  assign is_dec  = (op_e == OP_DEC);

  logic [W-1:0] ar_res;
  logic         ar_cout;
  logic         ar_half;

  acc_alu_arith #(.W(W)) u_arith (
    .a    (acc_in),
    .b    (operand),
    .cin  (uses_cy & fin.cy),
    .sub  (is_sub),
    .res  (ar_res),
    .cout (ar_cout),
    .half (ar_half)
  );

  logic [W-1:0] lg_res;
  logic         lg_half;

  acc_alu_logic #(.W(W)) u_logic (
    .op   (op_e),
    .a    (acc_in),
    .b    (operand),
    .res  (lg_res),
    .half (lg_half)
  );

  // Step unit for increment / decrement of the operand
  logic [W-1:0] st_res;
  logic         st_half;
  assign st_res  = is_dec ? operand - W'(1) : operand + W'(1);
  assign st_half = is_dec ? (operand[HW-1:0] == '0) : (operand[HW-1:0] == '1);

  logic [W-1:0] res_n;
  alu_flags_t   fl_n;
  logic         we_n;

  always_comb begin
    res_n = acc_in;
    fl_n  = fin;
    we_n  = 1'b0;
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_n   = ar_res;
        we_n    = 1'b1;
        fl_n.cy = ar_cout;
        fl_n.ac = ar_half;
        fl_n    = put_szp(fl_n, ar_res);
      end
      OP_CMP: begin
        fl_n.cy = ar_cout;
        fl_n.ac = ar_half;
        fl_n    = put_szp(fl_n, ar_res);
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_n   = lg_res;
        we_n    = 1'b1;
        fl_n.cy = 1'b0;
        fl_n.ac = lg_half;
        fl_n    = put_szp(fl_n, lg_res);
      end
      OP_INC, OP_DEC: begin
        res_n   = st_res;
        fl_n.ac = st_half;
        fl_n    = put_szp(fl_n, st_res);
      end
      OP_CMA: begin
        res_n = ~acc_in;
        we_n  = 1'b1;
      end
      OP_STC:  fl_n.cy = 1'b1;
      OP_CMC:  fl_n.cy = ~fin.cy;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      acc_we    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_n;
        flags_out <= fl_n;
        acc_we    <= we_n;
      end else begin
        acc_we    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic [3:0]                     op,
  input logic [W-1:0]                   operand,
  input logic [W-1:0]                   acc_in,
  input logic [acc_alu_pkg::FLAG_W-1:0] flags_in,
  input logic                           out_valid,
  input logic [W-1:0]                   result,
  input logic [acc_alu_pkg::FLAG_W-1:0] flags_out,
  input logic                           acc_we
);
  import acc_alu_pkg::*;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !acc_we)); // R1
  AST_ADD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ADD) |=> (flags_out[FL_P] == ~^result)); // R4
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=>
      (!flags_out[FL_CY] && acc_we)); // R5
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMP) |=> (!acc_we && result == $past(acc_in))); // R6
  AST_CMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMP) |=>
      (flags_out[FL_CY] == ($past(acc_in) < $past(operand)) &&
       flags_out[FL_Z]  == ($past(acc_in) == $past(operand)))); // R6
  AST_STEP_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_INC || op == OP_DEC)) |=>
      (flags_out[FL_CY] == $past(flags_in[FL_CY]) && !acc_we)); // R7
  AST_CMA_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMA) |=> (flags_out == $past(flags_in))); // R8
  AST_CARRY_OPS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_STC || op == OP_CMC)) |=>
      (flags_out[FLAG_W-1:1] == $past(flags_in[FLAG_W-1:1]) && !acc_we)); // R9

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] operand = '0;
  logic [7:0] acc_in = '0;
  logic [4:0] flags_in = '0;
  logic       out_valid;
  logic [7:0] result;
  logic [4:0] flags_out;
  logic       acc_we;

  int total = 0;
  int failed = 0;
  bit done = 0;

  logic [13:0] expq[$];
  string       tagq[$];

  always #2.5 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .operand(operand), .acc_in(acc_in), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .flags_out(flags_out),
    .acc_we(acc_we)
  );

  function automatic int even_ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  // Expected {result[7:0], flags{S,Z,AC,P,CY}, we}
  function automatic logic [13:0] model(input int code, input int a, input int b, input int f);
    int r = a, we = 0, cy = f & 1, ac = (f >> 2) & 1, s = (f >> 4) & 1;
    int z = (f >> 3) & 1, p = (f >> 1) & 1, szp = 0, c = f & 1, t;
    case (code)
      0, 1: begin
        if (code == 0) c = 0;
        t = a + b + c; r = t & 255; cy = (t > 255); we = 1; szp = 1;
        ac = ((a & 15) + (b & 15) + c) > 15;
      end
      2, 3, 7: begin
        if (code == 2 || code == 7) c = 0;
        t = a - b - c; cy = (t < 0); szp = 1;
        ac = ((a & 15) - (b & 15) - c) < 0;
        r = t & 255;
        if (code != 7) we = 1;
      end
      4, 5, 6: begin
        r = (code == 4) ? (a & b) : (code == 5) ? (a | b) : (a ^ b);
        cy = 0; ac = (code == 4); we = 1; szp = 1;
      end
      8: begin r = (b + 1) & 255; ac = ((b & 15) == 15); szp = 1; end
      9: begin r = (b + 255) & 255; ac = ((b & 15) == 0); szp = 1; end
      10: begin r = (~a) & 255; we = 1; end
      11: cy = 1;
      12: cy = 1 - cy;
      default: ;
    endcase
    if (szp) begin
      s = (r >> 7) & 1; z = (r == 0); p = even_ones(r);
    end
    if (code == 7) r = a;
    return {r[7:0], s[0], z[0], ac[0], p[0], cy[0], we[0]};
  endfunction

  function automatic string tag_of(input int code);
    case (code)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5, 6: return "R5";
      7:       return "R6";
      8, 9:    return "R7";
      10:      return "R8";
      11, 12:  return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic send(input int code, input int a, input int b, input int f, input string tg);
    @(negedge clk);
    in_valid = 1'b1; op = code[3:0]; acc_in = a[7:0]; operand = b[7:0]; flags_in = f[4:0];
    expq.push_back(model(code, a, b, f));
    tagq.push_back(tg);
  endtask

  task automatic gap();
    @(negedge clk);
    in_valid = 1'b0;
    op = 4'd0;
  endtask

  // Monitor: compare each produced outcome with the scoreboard
  initial begin
    logic v;
    logic [13:0] e;
    string tg;
    forever begin
      @(posedge clk);
      v = in_valid && rst_n;
      #1;
      if (rst_n) begin
        if (out_valid !== v) begin
          total++; failed++;
          $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, v);
        end
        if (v && expq.size() > 0) begin
          e = expq.pop_front(); tg = tagq.pop_front();
          total++;
          if ({result, flags_out, acc_we} !== e) begin
            failed++;
            $display("FAIL %s result/flags/we actual=%02h/%05b/%0b expected=%02h/%05b/%0b",
                     tg, result, flags_out, acc_we, e[13:6], e[5:1], e[0]);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    total++; failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int seed = 32'h1234_5678;
    int a, b, f;
    // R1: reset state
    repeat (3) @(negedge clk);
    total++;
    if ({out_valid, result, flags_out, acc_we} !== 15'd0) begin
      failed++;
      $display("FAIL R1 reset outputs actual=%0b/%02h/%05b/%0b expected=0/00/00000/0",
               out_valid, result, flags_out, acc_we);
    end
    rst_n = 1'b1;
    gap(); gap();

    // R4: worked example 0x44 + 0x73 -> 0xB7, flags 10010
    total++;
    if (model(0, 8'h44, 8'h73, 0) !== {8'hB7, 5'b10010, 1'b1}) begin
      failed++;
      $display("FAIL R4 model example actual=%h expected=%h", model(0, 8'h44, 8'h73, 0),
               {8'hB7, 5'b10010, 1'b1});
    end
    send(0, 8'h44, 8'h73, 0, "R4");
    gap();

    // Corner cases
    send(0, 8'hFF, 8'h01, 0, "R2");      // carry out of bit 7, zero
    send(1, 8'h0F, 8'h00, 1, "R2");      // carry-in crossing bit 3
    send(1, 8'h7F, 8'h80, 1, "R2");      // carry chain through all bits
    send(2, 8'h10, 8'h01, 0, "R3");      // borrow into bit 4
    send(3, 8'h00, 8'h00, 1, "R3");      // borrow-in wraps to FF
    send(2, 8'h05, 8'h05, 5'b11111, "R3");
    send(7, 8'h15, 8'hC2, 0, "R6");      // A < operand
    send(7, 8'h7A, 8'h25, 1, "R6");      // A > operand
    send(7, 8'h42, 8'h42, 0, "R6");      // equal
    send(4, 8'hF0, 8'h0F, 1, "R5");
    send(5, 8'h00, 8'h00, 5'b00101, "R5");
    send(6, 8'hAA, 8'hAA, 1, "R5");
    send(8, 8'h00, 8'hFF, 1, "R7");      // increment wraps
    send(9, 8'h00, 8'h00, 0, "R7");      // decrement wraps
    send(9, 8'h00, 8'h10, 1, "R7");
    send(10, 8'h5A, 8'h00, 5'b10101, "R8");
    send(11, 8'h33, 8'h00, 5'b01010, "R9");
    send(12, 8'h33, 8'h00, 5'b01011, "R9");
    send(13, 8'h12, 8'h34, 5'b11011, "R10");
    send(15, 8'h99, 8'hFF, 5'b00100, "R10");
    gap();

    // Sweep all codes with pseudo-random values, idle gaps in between
    for (int k = 0; k < 40; k++) begin
      for (int c = 0; c < 16; c++) begin
        seed = seed * 1103515245 + 12345;
        a = (seed >> 8) & 255;
        b = (seed >> 16) & 255;
        f = (seed >> 3) & 31;
        send(c, a, b, f, tag_of(c));
      end
      if (k % 4 == 0) gap();
    end
    gap(); gap(); gap();

    total++;
    if (expq.size() != 0) begin
      failed++;
      $display("FAIL R1 outcomes missing actual=%0d expected=0", expq.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule